// File: doc/BRIEF.md
# Grouped Priority Interrupt Resolver

The resolver watches a fixed set of interrupt groups. Each group has up to four sources, and each source carries a request bit and an enable bit. The lowest-numbered groups are non-maskable; all others are maskable and carry a 3-bit priority level. Every cycle the block searches the maskable groups for the most urgent pending one and drives that group's level to the processor. A smaller level value is more urgent. Level 7 means that nothing is pending.

When a non-maskable group gains a pending enabled source, the block emits a one-cycle non-maskable request pulse. When the processor acknowledges a maskable interrupt, it sends the level it believes it accepted. The block then latches the group behind the currently driven level into an accepted-group register, which the processor reads back as a byte. If the processor sends a level that disagrees with the driven one, a sticky error flag is set.

The request, enable and level bits come from a register bank outside the block, as flat parallel vectors.

Top module: `irq_prio_resolver`

## Requirements
- R1: A group is pending when the bitwise AND of its 4-bit request field and its 4-bit enable field is nonzero. Group g occupies bits [4g+3:4g] of `src_req` and `src_en`. A request whose enable is clear never affects any output.
- R2: Among the pending maskable groups (2 to 30), the one with the numerically smallest level is chosen. Group g's level sits in bits [3(g-2)+2:3(g-2)] of `grp_lvl`.
- R3: When pending maskable groups share the smallest level, the lowest group number is chosen.
- R4: With no pending maskable group, `cpu_level` is 7 and the selected group is 0. A pending group whose level is 7 is never chosen.
- R5: `cpu_level` reflects the inputs sampled at the previous rising clock edge (one register stage).
- R6: `nmi_pulse` is high for exactly one cycle, one cycle after the edge where group 0 or group 1 first has a pending source. It pulses again only after both groups have gone idle. Non-maskable groups never influence `cpu_level`.
- R7: When `ack_valid` is sampled high, the group behind the currently driven `cpu_level` is latched into the accepted-group register. Otherwise that register holds its value.
- R8: With `rd_byte_sel`=0, `acc_rd_data` is the accepted group number shifted left by 2, or 0 if that group has no pending request at present. With `rd_byte_sel`=1 it is always 0.
- R9: `sync_err` is set, and stays set until reset, one cycle after an acknowledge whose `ack_level` differs from the driven `cpu_level`.
- R10: Synchronous active-high reset gives `cpu_level`=7, accepted group 0, `nmi_pulse`=0 and `sync_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 124 | Request bits, 4 per group |
| src_en | input | 124 | Enable bits, 4 per group |
| grp_lvl | input | 87 | Level, 3 bits per maskable group |
| ack_valid | input | 1 | Processor acknowledge strobe |
| ack_level | input | 3 | Level the processor accepted |
| rd_byte_sel | input | 1 | Accepted-group read byte select |
| cpu_level | output | 3 | Driven interrupt level (7 = none) |
| nmi_pulse | output | 1 | Non-maskable request pulse |
| acc_rd_data | output | 8 | Accepted-group readback byte |
| sync_err | output | 1 | Sticky acknowledge-level mismatch flag |

## Verification
The bench targets several corner cases, each with a characteristic failure:
- Equal levels in several groups: a non-strict comparison would let a higher group number win the tie.
- Groups at level 7: if these were allowed to win, the block would report group data while driving "no interrupt".
- Requests with their enables cleared: these expose a design that ignores the mask.
- A request that disappears after it was acknowledged: a readback taken from the latched number alone would still return a stale, nonzero group.
- A non-maskable source held high: an edge detector built wrongly would repeat the pulse.
- An acknowledge carrying the wrong level: this must set the error flag, and the flag must stay set.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  // Strictly-smaller comparison: a candidate replaces the current choice only when more urgent.
  function automatic logic lvl_more_urgent(input int cand, input int cur);
    return cand < cur;
  endfunction

  // Readback byte: group number in bits above the two low zeros, or zero when the request vanished.
  function automatic logic [7:0] acc_byte(input int grp, input logic still_pending);
    logic [7:0] b;
    b = 8'(grp) << 2;
    return still_pending ? b : 8'h00;
  endfunction

endpackage

// File: rtl/irq_pend_detect.sv
module irq_pend_detect #(
  parameter int NUM_GROUPS = 31,
  parameter int SRC_W      = 4
) (
  input  logic [NUM_GROUPS*SRC_W-1:0] req_bits,
  input  logic [NUM_GROUPS*SRC_W-1:0] en_bits,
  output logic [NUM_GROUPS-1:0]       pend
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign pend[g] = |(req_bits[g*SRC_W +: SRC_W] & en_bits[g*SRC_W +: SRC_W]);
  end
endmodule

// File: rtl/irq_prio_scan.sv
module irq_prio_scan
  import irq_prio_pkg::*;
#(
  parameter int NUM_GROUPS = 31,
  parameter int NUM_NMI    = 2,
  parameter int LVL_W      = 3,
  localparam int GRP_W     = $clog2(NUM_GROUPS),
  localparam int NUM_MASK  = NUM_GROUPS - NUM_NMI
) (
  input  logic [NUM_MASK-1:0]       pend_mask,
  input  logic [NUM_MASK*LVL_W-1:0] lvl_bits,
  output logic [GRP_W-1:0]          sel_grp,
  output logic [LVL_W-1:0]          sel_lvl
);
  localparam logic [LVL_W-1:0] IDLE_LVL = {LVL_W{1'b1}};

  always_comb begin
    sel_grp = '0;
    sel_lvl = IDLE_LVL;
    for (int i = 0; i < NUM_MASK; i++) begin
      if (pend_mask[i] &&
          lvl_more_urgent(int'(lvl_bits[i*LVL_W +: LVL_W]), int'(sel_lvl))) begin
        sel_grp = GRP_W'(i + NUM_NMI);
        sel_lvl = lvl_bits[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/irq_accept_reg.sv
module irq_accept_reg
  import irq_prio_pkg::*;
#(
  parameter int NUM_GROUPS = 31,
  parameter int LVL_W      = 3,
  localparam int GRP_W     = $clog2(NUM_GROUPS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ack_valid,
  input  logic [LVL_W-1:0]      ack_level,
  input  logic [GRP_W-1:0]      cur_grp,
  input  logic [LVL_W-1:0]      cur_lvl,
  input  logic [NUM_GROUPS-1:0] pend,
  input  logic                  rd_byte_sel,
  output logic [7:0]            rd_data,
  output logic [GRP_W-1:0]      acc_grp,
  output logic                  sync_err
);
  logic acc_live;
  logic lvl_mismatch;

  assign lvl_mismatch = ack_valid && (ack_level != cur_lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_grp  <= '0;
      sync_err <= 1'b0;
    end else begin
      if (ack_valid)    acc_grp  <= cur_grp;
      if (lvl_mismatch) sync_err <= 1'b1;
    end
  end

  always_comb begin
    acc_live = 1'b0;
    for (int g = 0; g < NUM_GROUPS; g++)
      if (GRP_W'(g) == acc_grp) acc_live = pend[g];
  end

  assign rd_data = rd_byte_sel ? 8'h00 : acc_byte(int'(acc_grp), acc_live);
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
  parameter int NUM_GROUPS = 31,
  parameter int NUM_NMI    = 2,
  parameter int SRC_W      = 4,
  parameter int LVL_W      = 3,
  localparam int GRP_W     = $clog2(NUM_GROUPS),
  localparam int NUM_MASK  = NUM_GROUPS - NUM_NMI
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_GROUPS*SRC_W-1:0] src_req,
  input  logic [NUM_GROUPS*SRC_W-1:0] src_en,
  input  logic [NUM_MASK*LVL_W-1:0]   grp_lvl,
  input  logic                        ack_valid,
  input  logic [LVL_W-1:0]            ack_level,
  input  logic                        rd_byte_sel,
  output logic [LVL_W-1:0]            cpu_level,
  output logic                        nmi_pulse,
  output logic [7:0]                  acc_rd_data,
  output logic                        sync_err
);
  logic [NUM_GROUPS-1:0] pend;
  logic [GRP_W-1:0]      scan_grp;
  logic [LVL_W-1:0]      scan_lvl;
  logic [GRP_W-1:0]      sel_grp_q;
  logic [LVL_W-1:0]      sel_lvl_q;
  logic [GRP_W-1:0]      acc_grp;
  logic                  nmi_any;
  logic                  nmi_any_q;
  logic                  nmi_rise;

  irq_pend_detect #(.NUM_GROUPS(NUM_GROUPS), .SRC_W(SRC_W)) u_pend (
    .req_bits (src_req),
    .en_bits  (src_en),
    .pend     (pend)
  );

  irq_prio_scan #(.NUM_GROUPS(NUM_GROUPS), .NUM_NMI(NUM_NMI), .LVL_W(LVL_W)) u_scan (
    .pend_mask (pend[NUM_GROUPS-1:NUM_NMI]),
    .lvl_bits  (grp_lvl),
    .sel_grp   (scan_grp),
    .sel_lvl   (scan_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_grp_q <= '0;
      sel_lvl_q <= {LVL_W{1'b1}};
      nmi_any_q <= 1'b0;
      nmi_pulse <= 1'b0;
    end else begin
      sel_grp_q <= scan_grp;
      sel_lvl_q <= scan_lvl;
      nmi_any_q <= nmi_any;
      nmi_pulse <= nmi_rise;
    end
  end

  assign nmi_any   = |pend[NUM_NMI-1:0];
  assign nmi_rise  = nmi_any && !nmi_any_q;
  assign cpu_level = sel_lvl_q;

  irq_accept_reg #(.NUM_GROUPS(NUM_GROUPS), .LVL_W(LVL_W)) u_acc (
    .clk         (clk),
    .rst         (rst),
    .ack_valid   (ack_valid),
    .ack_level   (ack_level),
    .cur_grp     (sel_grp_q),
    .cur_lvl     (sel_lvl_q),
    .pend        (pend),
    .rd_byte_sel (rd_byte_sel),
    .rd_data     (acc_rd_data),
    .acc_grp     (acc_grp),
    .sync_err    (sync_err)
  );
endmodule

// File: rtl/irq_prio_resolver_chk.sv
module irq_prio_resolver_chk #(
  parameter int GRP_W = 5,
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             ack_valid,
  input logic [LVL_W-1:0] ack_level,
  input logic             rd_byte_sel,
  input logic [LVL_W-1:0] cpu_level,
  input logic             nmi_pulse,
  input logic [7:0]       acc_rd_data,
  input logic             sync_err,
  input logic [GRP_W-1:0] sel_grp_q,
  input logic [GRP_W-1:0] acc_grp
);
  p_reset_r10: assert property (@(posedge clk)
    rst |=> (cpu_level == {LVL_W{1'b1}} && acc_grp == '0 && !sync_err && !nmi_pulse));

  p_idle_means_grp0_r4: assert property (@(posedge clk) disable iff (rst)
    (cpu_level == {LVL_W{1'b1}}) == (sel_grp_q == '0));

  p_nmi_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    nmi_pulse |=> !nmi_pulse);

  p_ack_latch_r7: assert property (@(posedge clk) disable iff (rst)
    ack_valid |=> acc_grp == $past(sel_grp_q));

  p_acc_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !ack_valid |=> $stable(acc_grp));

  p_byte1_zero_r8: assert property (@(posedge clk) disable iff (rst)
    rd_byte_sel |-> acc_rd_data == 8'h00);

  p_err_set_r9: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && ack_level != cpu_level) |=> sync_err);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    sync_err |=> sync_err);
endmodule

bind irq_prio_resolver irq_prio_resolver_chk #(.GRP_W(GRP_W), .LVL_W(LVL_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ack_valid   (ack_valid),
  .ack_level   (ack_level),
  .rd_byte_sel (rd_byte_sel),
  .cpu_level   (cpu_level),
  .nmi_pulse   (nmi_pulse),
  .acc_rd_data (acc_rd_data),
  .sync_err    (sync_err),
  .sel_grp_q   (sel_grp_q),
  .acc_grp     (acc_grp)
);

// File: tb/irq_prio_resolver_tb.sv
`timescale 1ns/1ps
module irq_prio_resolver_tb;
  localparam int NG = 31;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NG*4-1:0] src_req = '0;
  logic [NG*4-1:0] src_en  = '0;
  logic [(NG-2)*3-1:0] grp_lvl = '0;
  logic           ack_valid = 1'b0;
  logic [2:0]     ack_level = 3'd0;
  logic           rd_byte_sel = 1'b0;
  logic [2:0]     cpu_level;
  logic           nmi_pulse;
  logic [7:0]     acc_rd_data;
  logic           sync_err;

  int checks = 0;
  int fails  = 0;

  // reference model state
  int m_lvl = 7, m_grp = 0, m_acc = 0;
  bit m_err = 0, m_nmi = 0, m_nmi_prev = 0;

  always #2.5 clk = ~clk;

  irq_prio_resolver u_dut (
    .clk(clk), .rst(rst), .src_req(src_req), .src_en(src_en), .grp_lvl(grp_lvl),
    .ack_valid(ack_valid), .ack_level(ack_level), .rd_byte_sel(rd_byte_sel),
    .cpu_level(cpu_level), .nmi_pulse(nmi_pulse), .acc_rd_data(acc_rd_data),
    .sync_err(sync_err)
  );

  function automatic bit is_pend(int g);
    for (int k = 0; k < 4; k++)
      if (src_req[g*4+k] === 1'b1 && src_en[g*4+k] === 1'b1) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int lvl_of(int g);
    return int'(grp_lvl[(g-2)*3 +: 3]);
  endfunction

  always @(posedge clk) begin
    int best_l, best_g;
    if (rst) begin
      m_lvl = 7; m_grp = 0; m_acc = 0; m_err = 0; m_nmi = 0; m_nmi_prev = 0;
    end else begin
      if (ack_valid) begin
        if (int'(ack_level) != m_lvl) m_err = 1;
        m_acc = m_grp;
      end
      best_l = 7; best_g = 0;
      for (int g = 2; g < NG; g++)
        if (is_pend(g) && lvl_of(g) < best_l) begin best_l = lvl_of(g); best_g = g; end
      m_lvl = best_l; m_grp = best_g;
      m_nmi = (is_pend(0) || is_pend(1)) && !m_nmi_prev;
      m_nmi_prev = is_pend(0) || is_pend(1);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    int exp_rd;
    @(negedge clk);
    exp_rd = rd_byte_sel ? 0 : (is_pend(m_acc) ? (m_acc << 2) : 0);
    chk("R1/R2/R3/R4/R5 cpu_level", int'(cpu_level), m_lvl);
    chk("R6 nmi_pulse", int'(nmi_pulse), int'(m_nmi));
    chk("R7/R8 acc_rd_data", int'(acc_rd_data), exp_rd);
    chk("R9 sync_err", int'(sync_err), int'(m_err));
  endtask

  task automatic set_grp(int g, logic [3:0] r, logic [3:0] e, logic [2:0] l);
    src_req[g*4 +: 4] = r;
    src_en[g*4 +: 4]  = e;
    if (g >= 2) grp_lvl[(g-2)*3 +: 3] = l;
  endtask

  task automatic clear_all();
    src_req = '0; src_en = '0;
  endtask

  task automatic do_ack(int lvl);
    ack_valid = 1'b1; ack_level = 3'(lvl);
    tick();
    ack_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    // R10: reset values
    chk("R10 level after reset", int'(cpu_level), 7);
    chk("R10 readback after reset", int'(acc_rd_data), 0);
    tick();

    // R1 masked request has no effect
    set_grp(5, 4'b0110, 4'b1001, 3'd2); tick(); tick();
    chk("R1 masked level", int'(cpu_level), 7);
    set_grp(5, 4'b0110, 4'b0100, 3'd2); tick();
    chk("R5 one-cycle latency", int'(cpu_level), 2);
    // R2 lower level wins
    set_grp(20, 4'b0001, 4'b0001, 3'd1); tick();
    chk("R2 lower level wins", int'(cpu_level), 1);
    // R3 tie -> lowest group
    set_grp(9, 4'b1000, 4'b1000, 3'd1); tick();
    do_ack(1); tick();
    chk("R3 tie picks group 9", int'(acc_rd_data), 9 << 2);
    // R8 byte1 zero
    rd_byte_sel = 1'b1; tick();
    chk("R8 byte1 zero", int'(acc_rd_data), 0);
    rd_byte_sel = 1'b0;
    // R8 request vanished -> 0
    set_grp(9, 4'b0000, 4'b1000, 3'd1); tick();
    chk("R8 vanished request reads 0", int'(acc_rd_data), 0);
    chk("R3 now group 20 level", int'(cpu_level), 1);
    // R4 level 7 pending never wins
    clear_all(); set_grp(3, 4'b1111, 4'b1111, 3'd7); tick(); tick();
    chk("R4 level7 idle", int'(cpu_level), 7);
    do_ack(7); tick();
    chk("R4 ack of idle latches group 0", int'(acc_rd_data), 0);
    // R6 NMI behaviour
    clear_all(); set_grp(0, 4'b0100, 4'b0100, 3'd0); tick();
    chk("R6 pulse", int'(nmi_pulse), 1);
    chk("R6 nmi does not drive level", int'(cpu_level), 7);
    repeat (3) tick();
    set_grp(1, 4'b0001, 4'b0001, 3'd0); tick();
    chk("R6 no repeat while held", int'(nmi_pulse), 0);
    clear_all(); tick(); tick();
    set_grp(1, 4'b0010, 4'b0010, 3'd0); tick();
    chk("R6 pulse again after idle", int'(nmi_pulse), 1);
    clear_all(); tick();
    // R9 wrong ack level
    set_grp(30, 4'b0001, 4'b0001, 3'd4); tick();
    do_ack(2); tick();
    chk("R9 error set", int'(sync_err), 1);
    chk("R7 ack latched group 30", int'(acc_rd_data), 30 << 2);
    repeat (3) tick();
    chk("R9 error sticky", int'(sync_err), 1);
    rst = 1'b1; tick(); rst = 1'b0; tick();
    chk("R10 error cleared by reset", int'(sync_err), 0);

    // randomized phase
    for (int n = 0; n < 600; n++) begin
      int g;
      g = $urandom_range(0, NG-1);
      set_grp(g, 4'($urandom), 4'($urandom), 3'($urandom));
      if ($urandom_range(0, 3) == 0) set_grp($urandom_range(0, NG-1), 4'h0, 4'h0, 3'd0);
      rd_byte_sel = ($urandom_range(0, 7) == 0);
      ack_valid = ($urandom_range(0, 4) == 0);
      ack_level = ($urandom_range(0, 15) == 0) ? 3'($urandom) : 3'(m_lvl);
      tick();
    end
    ack_valid = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule